// File: doc/BRIEF.md
# Four-Channel Voice and Melody Mixer

This block combines four 8-bit audio channels into three output sample codes: two DAC codes and one PWM code. Samples are offset binary around 80h. A channel in voice mode passes its written sample straight through. A channel in melody mode gates its sample with a square tone. The tone toggles on every tick from that channel's timer. While the tone is low the channel contributes 80h (silence), and while it is high it contributes its data. In that case the sample value above 80h acts as envelope amplitude.

A play-mode register can gang channels so that followers copy a leader's data, mode and tone phase. Leaders are channel 1, or channel 3 for the pair 3 and 4. Each output averages its contributing channels about 80h and then scales the result by its own 4-bit volume. An audio control register holds the DAC enable, the merged/separate choice and the PWM enable. The block also forwards each timer tick as an interrupt pulse, except for channels in melody mode, where the tick is used by the tone instead.

Top module: `voice_mixer`

## Requirements
- R1: After reset the channel data registers hold 80h, the play mode, audio control and volume registers hold 0, all tone phases are low, all three codes are 80h, and all valid strobes and interrupt outputs are 0.
- R2: Register writes use `wr_addr`: 0–3 for channel 1–4 data, 4 for play mode, 5 for audio control, 6 for DAC1 volume, 7 for DAC2 volume and 8 for PWM volume. Volumes take `wr_data[3:0]`. Other addresses are ignored. With offsets s = sample − 128 and floor division, an enabled output code is 128 + floor(avg·(vol+1)/16). In separate mode, DAC1 averages channels 1 and 2 as floor((s1+s2)/2).
- R3: Play-mode bit i−1 set puts channel i in melody mode. Its tone phase toggles on each clock with its tick high and is held low while the channel is in voice mode. A melody channel contributes 80h while its phase is low and its data while the phase is high.
- R4: `irq_out[i]` is high for one cycle after a clock edge at which `tick[i]` was high and channel i was in voice mode. It is never raised for a channel in melody mode.
- R5: Play-mode bit 4 makes channel 2 follow channel 1 and channel 4 follow channel 3's own registers.
- R6: Play-mode bit 5 makes channels 2 and 3 follow channel 1.
- R7: Play-mode bit 6 makes channel 3 follow channel 1.
- R8: Play-mode bit 7 makes channels 2, 3 and 4 follow channel 1, and it takes priority over bit 4 for channel 4.
- R9: Audio control bit 1 = 1 selects separate mode, where DAC2 averages channels 3 and 4. Bit 1 = 0 selects merged mode, where both DACs output floor((s1+s2+s3+s4)/4), each scaled by its own volume.
- R10: PWM outputs the four-channel average scaled by the PWM volume while audio control bit 2 is 1. Otherwise it outputs 80h with `pwm_vld` low.
- R11: While audio control bit 0 is 0, both DAC codes are 80h and both DAC valid strobes are low. While it is 1, both strobes are high.
- R12: A register write or tick captured at clock edge k shows on the codes after edge k+1, and the codes after edge k still reflect the earlier state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select |
| wr_data | input | 8 | Write data |
| tick | input | 4 | Timer tick pulses, one per channel |
| irq_out | output | 4 | Forwarded timer interrupts (voice-mode channels only) |
| dac1_code | output | 8 | DAC1 sample code |
| dac1_vld | output | 1 | DAC1 sample valid |
| dac2_code | output | 8 | DAC2 sample code |
| dac2_vld | output | 1 | DAC2 sample valid |
| pwm_code | output | 8 | PWM sample code |
| pwm_vld | output | 1 | PWM sample valid |

## Verification
On every cycle the assertions check these properties:
- a ticked melody channel flips its tone phase, and an idle one holds it;
- interrupts are forwarded for voice channels and masked for melody channels;
- a disabled output parks at 80h with its strobe low;
- an enabled output raises its strobe.

The arithmetic of averaging and volume scaling, the ganging priorities between play-mode bits, and the one-cycle write-to-output latency can only be shown by the bench's scenarios. In those scenarios a reference model tracks every register and tone phase.

// File: rtl/voice_mixer_pkg.sv
package voice_mixer_pkg;
  localparam int SMP_W  = 8;
  localparam int VOL_W  = 4;
  localparam int NCH    = 4;
  localparam int ADDR_W = 4;
  localparam int NOUT   = 3;
  localparam int SUM_W  = SMP_W + 2;
  localparam int MUL_W  = SUM_W + VOL_W + 2;
  localparam logic [SMP_W-1:0] MID = SMP_W'(1) << (SMP_W - 1);

  typedef logic [SMP_W-1:0] smp_t;
  typedef logic signed [SMP_W:0] ofs_t;

  typedef enum logic [ADDR_W-1:0] {
    A_CH1 = 4'd0, A_CH2 = 4'd1, A_CH3 = 4'd2, A_CH4 = 4'd3,
    A_PLAY = 4'd4, A_AUD = 4'd5,
    A_VOL1 = 4'd6, A_VOL2 = 4'd7, A_VOLP = 4'd8
  } reg_addr_e;

  function automatic ofs_t to_ofs(smp_t v);
    return $signed({1'b0, v}) - $signed({1'b0, MID});
  endfunction

  // avg * (vol+1) / 16 with floor, re-centred on MID
  function automatic smp_t scale(logic signed [SUM_W-1:0] avg, logic [VOL_W-1:0] vol);
    logic signed [MUL_W-1:0] a_w;
    logic signed [MUL_W-1:0] m_w;
    logic signed [MUL_W-1:0] p;
    a_w = MUL_W'(avg);
    m_w = MUL_W'({2'b00, vol}) + MUL_W'(1);
    p   = (a_w * m_w) >>> VOL_W;
    return {~p[SMP_W-1], p[SMP_W-2:0]};
  endfunction
endpackage

// File: rtl/voice_mixer_chan.sv
module voice_mixer_chan
  import voice_mixer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic melody,
  input  logic tick,
  input  smp_t data,
  output smp_t level,
  output logic irq
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      irq   <= 1'b0;
    end else begin
      phase <= melody ? (phase ^ tick) : 1'b0;
      irq   <= tick & ~melody;
    end
  end

  assign level = (melody && !phase) ? MID : data;

  p_tone_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (melody && tick) |=> (phase != $past(phase)));
  p_tone_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (melody && !tick) |=> $stable(phase));
  p_irq_masked_r4: assert property (@(posedge clk) disable iff (rst)
    melody |=> !irq);
  p_irq_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (!melody && tick) |=> irq);
endmodule

// File: rtl/voice_mixer_out.sv
module voice_mixer_out
  import voice_mixer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             all4,
  input  logic [VOL_W-1:0] vol,
  input  ofs_t             ofs_in [NCH],
  output smp_t             code,
  output logic             vld
);
  logic signed [SUM_W-1:0] sum2, sum4, avg;

  always_comb begin
    sum2 = SUM_W'(ofs_in[0]) + SUM_W'(ofs_in[1]);
    sum4 = '0;
    for (int i = 0; i < NCH; i++) sum4 = sum4 + SUM_W'(ofs_in[i]);
    avg = all4 ? (sum4 >>> 2) : (sum2 >>> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= MID;
      vld  <= 1'b0;
    end else begin
      vld  <= en;
      code <= en ? scale(avg, vol) : MID;
    end
  end

  p_off_silent_r10_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (code == MID && !vld));
  p_on_valid_r11: assert property (@(posedge clk) disable iff (rst)
    en |=> vld);
endmodule

// File: rtl/voice_mixer.sv
module voice_mixer
  import voice_mixer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SMP_W-1:0]  wr_data,
  input  logic [NCH-1:0]    tick,
  output logic [NCH-1:0]    irq_out,
  output logic [SMP_W-1:0]  dac1_code,
  output logic              dac1_vld,
  output logic [SMP_W-1:0]  dac2_code,
  output logic              dac2_vld,
  output logic [SMP_W-1:0]  pwm_code,
  output logic              pwm_vld
);
  smp_t             ch_q   [NCH];
  logic [7:0]       play_q;
  logic [2:0]       aud_q;
  logic [VOL_W-1:0] vol_q  [NOUT];
  smp_t             lvl    [NCH];
  logic [1:0]       src    [NCH];
  ofs_t             ofs_a  [NCH];
  ofs_t             ofs_b  [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) ch_q[i] <= MID;
      for (int i = 0; i < NOUT; i++) vol_q[i] <= '0;
      play_q <= '0;
      aud_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CH1:  ch_q[0]  <= wr_data;
        A_CH2:  ch_q[1]  <= wr_data;
        A_CH3:  ch_q[2]  <= wr_data;
        A_CH4:  ch_q[3]  <= wr_data;
        A_PLAY: play_q   <= wr_data;
        A_AUD:  aud_q    <= wr_data[2:0];
        A_VOL1: vol_q[0] <= wr_data[VOL_W-1:0];
        A_VOL2: vol_q[1] <= wr_data[VOL_W-1:0];
        A_VOLP: vol_q[2] <= wr_data[VOL_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    voice_mixer_chan u_ch (
      .clk(clk), .rst(rst), .melody(play_q[g]), .tick(tick[g]),
      .data(ch_q[g]), .level(lvl[g]), .irq(irq_out[g])
    );
  end

  // ganging: bit7 > bit4 for channel 4
  always_comb begin
    src[0] = 2'd0;
    src[1] = (play_q[4] | play_q[5] | play_q[7]) ? 2'd0 : 2'd1;
    src[2] = (play_q[5] | play_q[6] | play_q[7]) ? 2'd0 : 2'd2;
    src[3] = play_q[7] ? 2'd0 : (play_q[4] ? 2'd2 : 2'd3);
    for (int i = 0; i < NCH; i++) ofs_a[i] = to_ofs(lvl[src[i]]);
    ofs_b[0] = ofs_a[2];
    ofs_b[1] = ofs_a[3];
    ofs_b[2] = ofs_a[0];
    ofs_b[3] = ofs_a[1];
  end

  voice_mixer_out u_dac1 (
    .clk(clk), .rst(rst), .en(aud_q[0]), .all4(~aud_q[1]), .vol(vol_q[0]),
    .ofs_in(ofs_a), .code(dac1_code), .vld(dac1_vld)
  );
  voice_mixer_out u_dac2 (
    .clk(clk), .rst(rst), .en(aud_q[0]), .all4(~aud_q[1]), .vol(vol_q[1]),
    .ofs_in(ofs_b), .code(dac2_code), .vld(dac2_vld)
  );
  voice_mixer_out u_pwm (
    .clk(clk), .rst(rst), .en(aud_q[2]), .all4(1'b1), .vol(vol_q[2]),
    .ofs_in(ofs_a), .code(pwm_code), .vld(pwm_vld)
  );
endmodule

// File: tb/tb_voice_mixer.sv
module tb_voice_mixer;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst;
  logic wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] tick;
  logic [3:0] irq_out;
  logic [7:0] dac1_code, dac2_code, pwm_code;
  logic dac1_vld, dac2_vld, pwm_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_data [4];
  int m_play, m_aud;
  int m_vol [3];
  int m_ph [4];

  always #(CLK_P/2) clk = ~clk;

  voice_mixer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .irq_out(irq_out), .dac1_code(dac1_code), .dac1_vld(dac1_vld),
    .dac2_code(dac2_code), .dac2_vld(dac2_vld), .pwm_code(pwm_code), .pwm_vld(pwm_vld)
  );

  task automatic cmp(string tag, string name, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, name, got, exp);
    end
  endtask

  function automatic int src_of(int i);
    bit b4 = m_play[4], b5 = m_play[5], b6 = m_play[6], b7 = m_play[7];
    case (i)
      0: return 0;
      1: return (b4 || b5 || b7) ? 0 : 1;
      2: return (b5 || b6 || b7) ? 0 : 2;
      default: return b7 ? 0 : (b4 ? 2 : 3);
    endcase
  endfunction

  function automatic int ofs_of(int i);
    int j = src_of(i);
    int v = (m_play[j] && m_ph[j] == 0) ? 128 : m_data[j];
    return v - 128;
  endfunction

  function automatic int code_of(int avg, int vol, bit en);
    if (!en) return 128;
    return ((avg * (vol + 1)) >>> 4) + 128;
  endfunction

  task automatic check_outputs(string tag);
    int s0 = ofs_of(0), s1 = ofs_of(1), s2 = ofs_of(2), s3 = ofs_of(3);
    int a4 = (s0 + s1 + s2 + s3) >>> 2;
    bit sep = m_aud[1];
    int a1 = sep ? ((s0 + s1) >>> 1) : a4;
    int a2 = sep ? ((s2 + s3) >>> 1) : a4;
    cmp(tag, "dac1_code", dac1_code, code_of(a1, m_vol[0], m_aud[0]));
    cmp(tag, "dac2_code", dac2_code, code_of(a2, m_vol[1], m_aud[0]));
    cmp(tag, "pwm_code",  pwm_code,  code_of(a4, m_vol[2], m_aud[2]));
    cmp(tag, "dac1_vld", dac1_vld, m_aud[0]);
    cmp(tag, "dac2_vld", dac2_vld, m_aud[0]);
    cmp(tag, "pwm_vld",  pwm_vld,  m_aud[2]);
  endtask

  // one write or tick: R12 timing, R4 irq, then settled outputs
  task automatic op(bit we, int a, int d, bit [3:0] tk, string tag);
    int exp_irq = tk & ~m_play[3:0];
    @(negedge clk);
    wr_en = we; wr_addr = 4'(a); wr_data = 8'(d); tick = tk;
    @(negedge clk);
    wr_en = 0; tick = 0;
    cmp("R4", "irq_out", irq_out, exp_irq);
    check_outputs("R12 before");
    for (int i = 0; i < 4; i++)
      m_ph[i] = m_play[i] ? (m_ph[i] ^ tk[i]) : 0;
    if (we) begin
      case (a)
        0, 1, 2, 3: m_data[a] = d & 255;
        4: m_play = d & 255;
        5: m_aud = d & 7;
        6, 7, 8: m_vol[a-6] = d & 15;
        default: ;
      endcase
    end
    @(negedge clk);
    check_outputs(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; tick = 0;
    for (int i = 0; i < 4; i++) begin m_data[i] = 128; m_ph[i] = 0; end
    for (int i = 0; i < 3; i++) m_vol[i] = 0;
    m_play = 0; m_aud = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cmp("R1", "dac1_code", dac1_code, 8'h80);
    cmp("R1", "pwm_code", pwm_code, 8'h80);
    cmp("R1", "vld", {dac1_vld, dac2_vld, pwm_vld}, 0);
    cmp("R1", "irq_out", irq_out, 0);
    check_outputs("R1");

    // R2 voice passthrough, separate mode
    op(1, 5, 3, 0, "R11");
    op(1, 6, 15, 0, "R2");
    op(1, 0, 8'hFF, 0, "R2");
    op(1, 1, 8'hFF, 0, "R2");
    cmp("R2", "dac1 full", dac1_code, 8'hFF);
    op(1, 6, 0, 0, "R2");
    cmp("R2", "dac1 vol0", dac1_code, 8'h87);
    op(1, 6, 15, 0, "R2");
    op(1, 0, 0, 0, "R2");
    op(1, 1, 0, 0, "R2");
    cmp("R2", "dac1 min", dac1_code, 8'h00);
    op(1, 9, 8'h55, 0, "R2 ignored addr");
    cmp("R2", "dac1 after bad addr", dac1_code, 8'h00);

    // R3 melody on channel 1
    op(1, 1, 8'h80, 0, "R3");
    op(1, 0, 8'hF0, 0, "R3");
    op(1, 4, 8'h01, 0, "R3");
    cmp("R3", "tone low", dac1_code, 8'h80);
    op(0, 0, 0, 4'b0001, "R3");
    cmp("R3", "tone high", dac1_code, 8'hB8);
    op(0, 0, 0, 4'b0001, "R3");
    cmp("R3", "tone low again", dac1_code, 8'h80);
    op(0, 0, 0, 4'b0010, "R4");
    op(0, 0, 0, 4'b0011, "R4");

    // R5 bit4
    op(1, 7, 15, 0, "R5");
    op(1, 0, 8'hFF, 0, "R5");
    op(1, 1, 8'h00, 0, "R5");
    op(1, 2, 8'h00, 0, "R5");
    op(1, 3, 8'hC0, 0, "R5");
    op(1, 4, 8'h10, 0, "R5");
    cmp("R5", "dac1", dac1_code, 8'hFF);
    cmp("R5", "dac2", dac2_code, 8'h00);
    // R7 bit6
    op(1, 4, 8'h40, 0, "R7");
    cmp("R7", "dac2", dac2_code, 8'hDF);
    cmp("R7", "dac1", dac1_code, 8'h7F);
    // R6 bit5
    op(1, 4, 8'h20, 0, "R6");
    cmp("R6", "dac1", dac1_code, 8'hFF);
    cmp("R6", "dac2", dac2_code, 8'hDF);
    // R8 bit7 over bit4
    op(1, 4, 8'h90, 0, "R8");
    cmp("R8", "dac2", dac2_code, 8'hFF);

    // R9 merged
    op(1, 4, 0, 0, "R9");
    op(1, 1, 8'hFF, 0, "R9");
    op(1, 2, 8'hFF, 0, "R9");
    op(1, 3, 8'h00, 0, "R9");
    op(1, 7, 7, 0, "R9");
    op(1, 5, 1, 0, "R9");
    cmp("R9", "dac1 merged", dac1_code, 8'hBF);
    cmp("R9", "dac2 merged", dac2_code, 8'h9F);
    // R10 PWM
    op(1, 8, 15, 0, "R10");
    op(1, 5, 5, 0, "R10");
    cmp("R10", "pwm on", pwm_code, 8'hBF);
    cmp("R10", "pwm_vld on", pwm_vld, 1);
    op(1, 5, 1, 0, "R10");
    cmp("R10", "pwm off", pwm_code, 8'h80);
    // R11 DAC disable
    op(1, 5, 4, 0, "R11");
    cmp("R11", "dac1 off", dac1_code, 8'h80);
    cmp("R11", "dac_vld off", {dac1_vld, dac2_vld}, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 9);
      if (r < 6) op(1, $urandom_range(0, 15), $urandom_range(0, 255), 0, "R2-R11 rnd");
      else       op(0, 0, 0, 4'($urandom_range(0, 15)), "R3 rnd tick");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule